// File: doc/BRIEF.md
# PLL Step-Response Crossover and Overshoot Monitor

This block sits next to a phase-locked loop and measures, entirely in digital logic running on the VCO clock, how the loop recovers after a deliberate phase step. A one-cycle start pulse from the step injector arms it. From then on it compares the reference-clock edge and the feedback-clock edge of every reference cycle in a bang-bang fashion, which yields only the sign of the phase error. It counts reference cycles until that sign first reverses. That count is the crossover time, and it varies inversely with loop bandwidth.

Once the crossover is found, the block samples the feedback divider's running count at each reference edge. It keeps the largest sample as the peak overcorrection, which grows with jitter peaking. After a programmable number of reference cycles it raises done. Running alongside this, it reports the latest error sign as the residual static phase error and flags lock once the sign has alternated for a programmable run of cycles. A synchronous clear prepares it for the next run.

Top module: `step_resp_monitor`

## Requirements
- R1: Each pair of edges yields one decision on sign_o, visible the cycle after the later edge. sign_o=1 means early, where the feedback edge came strictly first. sign_o=0 means late, where the reference edge came first, and edges in the same cycle also count as late.
- R2: After start_i in the idle state, crossover_o counts the reference edges seen. The first decision sets the baseline sign. Counting stops at the first decision of opposite sign, and the reference edge of that cycle is included.
- R3: If the counter sits at 1023 and another reference edge arrives before any reversal, crossover_o holds at 1023, overflow_o is set and done_o is asserted.
- R4: The peak register resets to 0. It samples fb_count_i only at reference edges after the crossover, and only up to the end of the settle window. It updates only when the sample is strictly larger than the stored value.
- R5: done_o is asserted after exactly settle_i reference edges following crossover, or in the cycle after crossover when settle_i is 0. It then holds until clear.
- R6: A decision whose sign differs from the previous one increments an alternation count, saturating at 15. Any other decision resets the count to 0. locked_o is 1 while the count is at least lock_win_i.
- R7: clear_i resets crossover_o, overflow_o, overshoot_o, done_o, locked_o and sign_o to 0 on the next edge.
- R8: start_i is ignored while a run is tracking, settling or done.
- R9: After reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | VCO-domain clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clear_i | input | 1 | Synchronous clear before a run |
| start_i | input | 1 | Step-injected pulse that arms a run |
| ref_edge_i | input | 1 | Reference edge event, one cycle |
| fb_edge_i | input | 1 | Feedback edge event, one cycle |
| fb_count_i | input | 6 | Feedback divider running count |
| settle_i | input | 8 | Reference cycles to observe after crossover |
| lock_win_i | input | 4 | Alternations required for lock |
| crossover_o | output | 10 | Crossover count in reference cycles |
| overflow_o | output | 1 | Crossover counter saturated |
| overshoot_o | output | 6 | Largest sampled overcorrection |
| done_o | output | 1 | Measurement complete |
| locked_o | output | 1 | Lock indication |
| sign_o | output | 1 | Latest phase error sign, 1 = early |

## Verification
A lost baseline sign or a wrong reversal compare shows up as a crossover_o value that is off from the first flipping slot. It is visible at the end of that slot. A sampling enable that leaks into the tracking phase or outlives the settle window shows up as an overshoot_o larger than the maximum over the settle slots. A settle counter that is off by one moves done_o by a whole reference cycle, and overflow slips show within 1024 slots. Lock errors appear as locked_o values that differ from the alternation model on the very next decision.

// File: rtl/srm_pkg.sv
package srm_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_TRACK  = 2'd1,
    ST_SETTLE = 2'd2,
    ST_DONE   = 2'd3
  } srm_state_e;
endpackage

// File: rtl/srm_bbpd.sv
module srm_bbpd (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic ref_edge_i,
  input  logic fb_edge_i,
  output logic dec_vld_o,
  output logic dec_early_o
);
  logic ref_pend_q, fb_pend_q, ref_pend_d, fb_pend_d;
  logic vld_d, early_d;

  always_comb begin
    ref_pend_d = ref_pend_q;
    fb_pend_d  = fb_pend_q;
    vld_d      = 1'b0;
    early_d    = 1'b0;
    if (ref_edge_i && fb_edge_i) begin
      vld_d = 1'b1;
      if (fb_pend_q) early_d = 1'b1;
    end else if (ref_edge_i) begin
      if (fb_pend_q) begin
        vld_d     = 1'b1;
        early_d   = 1'b1;
        fb_pend_d = 1'b0;
      end else begin
        ref_pend_d = 1'b1;
      end
    end else if (fb_edge_i) begin
      if (ref_pend_q) begin
        vld_d      = 1'b1;
        ref_pend_d = 1'b0;
      end else begin
        fb_pend_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ref_pend_q  <= 1'b0;
      fb_pend_q   <= 1'b0;
      dec_vld_o   <= 1'b0;
      dec_early_o <= 1'b0;
    end else if (clear_i) begin
      ref_pend_q  <= 1'b0;
      fb_pend_q   <= 1'b0;
      dec_vld_o   <= 1'b0;
      dec_early_o <= 1'b0;
    end else begin
      ref_pend_q <= ref_pend_d;
      fb_pend_q  <= fb_pend_d;
      dec_vld_o  <= vld_d;
      if (vld_d) dec_early_o <= early_d;
    end
  end
endmodule

// File: rtl/srm_xover.sv
module srm_xover
  import srm_pkg::*;
#(
  parameter int unsigned XW = 10,
  parameter int unsigned SW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clear_i,
  input  logic          start_i,
  input  logic          ref_edge_i,
  input  logic          dec_vld_i,
  input  logic          dec_early_i,
  input  logic [SW-1:0] settle_i,
  output logic [XW-1:0] cnt_o,
  output logic          ovf_o,
  output logic          done_o,
  output logic          sample_o
);
  localparam logic [XW-1:0] CNT_MAX = {XW{1'b1}};

  srm_state_e    state_q, state_d;
  logic [XW-1:0] cnt_q, cnt_d;
  logic [SW-1:0] sc_q, sc_d;
  logic          have_q, have_d, base_q, base_d, ovf_q, ovf_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    sc_d    = sc_q;
    have_d  = have_q;
    base_d  = base_q;
    ovf_d   = ovf_q;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        state_d = ST_TRACK;
        cnt_d   = '0;
        have_d  = 1'b0;
      end
      ST_TRACK: begin
        if (ref_edge_i && cnt_q != CNT_MAX) cnt_d = cnt_q + 1'b1;
        if (dec_vld_i) begin
          if (!have_q) begin
            have_d = 1'b1;
            base_d = dec_early_i;
          end else if (dec_early_i != base_q) begin
            state_d = ST_SETTLE;
            sc_d    = '0;
          end
        end
        if (ref_edge_i && cnt_q == CNT_MAX) begin
          ovf_d   = 1'b1;
          state_d = ST_DONE;
        end
      end
      ST_SETTLE: begin
        if (settle_i == '0) state_d = ST_DONE;
        else if (ref_edge_i) begin
          sc_d = sc_q + 1'b1;
          if (sc_q + 1'b1 == settle_i) state_d = ST_DONE;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      sc_q    <= '0;
      have_q  <= 1'b0;
      base_q  <= 1'b0;
      ovf_q   <= 1'b0;
    end else if (clear_i) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      sc_q    <= '0;
      have_q  <= 1'b0;
      base_q  <= 1'b0;
      ovf_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      sc_q    <= sc_d;
      have_q  <= have_d;
      base_q  <= base_d;
      ovf_q   <= ovf_d;
    end
  end

  assign cnt_o    = cnt_q;
  assign ovf_o    = ovf_q;
  assign done_o   = (state_q == ST_DONE);
  assign sample_o = (state_q == ST_SETTLE) && ref_edge_i && (settle_i != '0);
endmodule

// File: rtl/srm_peak.sv
module srm_peak #(
  parameter int unsigned DW = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clear_i,
  input  logic          sample_i,
  input  logic [DW-1:0] val_i,
  output logic [DW-1:0] max_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      max_o <= '0;
    else if (clear_i)                 max_o <= '0;
    else if (sample_i && val_i > max_o) max_o <= val_i;
  end
endmodule

// File: rtl/srm_lock.sv
module srm_lock #(
  parameter int unsigned LW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clear_i,
  input  logic          dec_vld_i,
  input  logic          dec_early_i,
  input  logic [LW-1:0] win_i,
  output logic          locked_o
);
  localparam logic [LW-1:0] ALT_MAX = {LW{1'b1}};

  logic [LW-1:0] alt_q, alt_d;
  logic          prev_vld_q, prev_q;

  always_comb begin
    if (prev_vld_q && dec_early_i != prev_q)
      alt_d = (alt_q == ALT_MAX) ? alt_q : alt_q + 1'b1;
    else
      alt_d = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      alt_q      <= '0;
      prev_vld_q <= 1'b0;
      prev_q     <= 1'b0;
      locked_o   <= 1'b0;
    end else if (clear_i) begin
      alt_q      <= '0;
      prev_vld_q <= 1'b0;
      prev_q     <= 1'b0;
      locked_o   <= 1'b0;
    end else if (dec_vld_i) begin
      alt_q      <= alt_d;
      prev_vld_q <= 1'b1;
      prev_q     <= dec_early_i;
      locked_o   <= (alt_d >= win_i);
    end
  end
endmodule

// File: rtl/step_resp_monitor.sv
module step_resp_monitor #(
  parameter int unsigned XW = 10,
  parameter int unsigned DW = 6,
  parameter int unsigned SW = 8,
  parameter int unsigned LW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clear_i,
  input  logic          start_i,
  input  logic          ref_edge_i,
  input  logic          fb_edge_i,
  input  logic [DW-1:0] fb_count_i,
  input  logic [SW-1:0] settle_i,
  input  logic [LW-1:0] lock_win_i,
  output logic [XW-1:0] crossover_o,
  output logic          overflow_o,
  output logic [DW-1:0] overshoot_o,
  output logic          done_o,
  output logic          locked_o,
  output logic          sign_o
);
  logic dec_vld, dec_early, sample;

  srm_bbpd i_bbpd (
    .clk_i, .rst_ni, .clear_i, .ref_edge_i, .fb_edge_i,
    .dec_vld_o(dec_vld), .dec_early_o(dec_early)
  );

  srm_xover #(.XW(XW), .SW(SW)) i_xover (
    .clk_i, .rst_ni, .clear_i, .start_i, .ref_edge_i,
    .dec_vld_i(dec_vld), .dec_early_i(dec_early), .settle_i,
    .cnt_o(crossover_o), .ovf_o(overflow_o), .done_o(done_o), .sample_o(sample)
  );

  srm_peak #(.DW(DW)) i_peak (
    .clk_i, .rst_ni, .clear_i, .sample_i(sample), .val_i(fb_count_i),
    .max_o(overshoot_o)
  );

  srm_lock #(.LW(LW)) i_lock (
    .clk_i, .rst_ni, .clear_i, .dec_vld_i(dec_vld), .dec_early_i(dec_early),
    .win_i(lock_win_i), .locked_o(locked_o)
  );

  assign sign_o = dec_early;
endmodule

// File: rtl/srm_checker.sv
module srm_checker #(
  parameter int unsigned XW = 10,
  parameter int unsigned DW = 6
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          clear_i,
  input logic [XW-1:0] crossover_o,
  input logic          overflow_o,
  input logic [DW-1:0] overshoot_o,
  input logic          done_o,
  input logic          locked_o,
  input logic          sign_o
);
  a_r3_ovf_at_max: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overflow_o |-> (crossover_o == {XW{1'b1}} && done_o));

  a_r5_done_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !clear_i) |=> done_o);

  a_r2_count_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !clear_i) |=> $stable(crossover_o));

  a_r4_peak_monotonic: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clear_i |=> overshoot_o >= $past(overshoot_o));

  a_r7_clear_all: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (crossover_o == '0 && !overflow_o && overshoot_o == '0 &&
                 !done_o && !locked_o && !sign_o));
endmodule

bind step_resp_monitor srm_checker #(.XW(XW), .DW(DW)) i_srm_checker (
  .clk_i(clk_i), .rst_ni(rst_ni), .clear_i(clear_i),
  .crossover_o(crossover_o), .overflow_o(overflow_o), .overshoot_o(overshoot_o),
  .done_o(done_o), .locked_o(locked_o), .sign_o(sign_o)
);

// File: tb/test_step_resp_monitor.sv
module test_step_resp_monitor;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic clear_i = 0, start_i = 0, ref_edge_i = 0, fb_edge_i = 0;
  logic [5:0] fb_count_i = '0;
  logic [7:0] settle_i = '0;
  logic [3:0] lock_win_i = '0;
  logic [9:0] crossover_o;
  logic overflow_o, done_o, locked_o, sign_o;
  logic [5:0] overshoot_o;

  int errors = 0, checks = 0, cycles = 0;
  bit finished = 0;
  bit sg [0:1099];
  int ct [0:1099];

  always #(CLK_PERIOD/2) clk = ~clk;

  step_resp_monitor i_step_resp_monitor (
    .clk_i(clk), .rst_ni, .clear_i, .start_i, .ref_edge_i, .fb_edge_i,
    .fb_count_i, .settle_i, .lock_win_i, .crossover_o, .overflow_o,
    .overshoot_o, .done_o, .locked_o, .sign_o
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(bit r, bit f, bit s, bit c);
    @(negedge clk);
    ref_edge_i = r; fb_edge_i = f; start_i = s; clear_i = c;
  endtask

  // one reference cycle: first edge at offset 0, second at offset 3
  task automatic slot(bit early, int cnt, bit st);
    fb_count_i = cnt[5:0];
    for (int o = 0; o < 8; o++) begin
      if (o == 0)      tick(!early, early, 1'b0, 1'b0);
      else if (o == 3) tick(early, !early, 1'b0, 1'b0);
      else if (o == 6) tick(1'b0, 1'b0, st, 1'b0);
      else             tick(1'b0, 1'b0, 1'b0, 1'b0);
    end
  endtask

  task automatic do_clear();
    tick(0, 0, 0, 1);
    tick(0, 0, 0, 0);
  endtask

  task automatic run(string tag, int n, int settle, int win, int extra_start);
    int k, ecross, emax, alt, prevv, prev;
    bit eovf, edone, elock;
    settle_i = settle[7:0]; lock_win_i = win[3:0];
    do_clear();
    chk("R7 cross cleared", int'(crossover_o), 0);
    chk("R7 done cleared", int'(done_o), 0);
    tick(0, 0, 1, 0);
    for (int i = 0; i < n; i++) slot(sg[i], ct[i], i == extra_start);
    tick(0, 0, 0, 0);
    k = -1;
    for (int i = 1; i < n && i < 1024; i++) if (k < 0 && sg[i] != sg[0]) k = i;
    eovf = 0; edone = 0; emax = 0;
    if (k < 0) begin
      eovf = (n >= 1024); edone = eovf; ecross = (n >= 1024) ? 1023 : n;
    end else begin
      ecross = k + 1;
      for (int j = k + 1; j < n && j <= k + settle; j++) if (ct[j] > emax) emax = ct[j];
      edone = (n - 1 - k) >= settle;
    end
    alt = 0; prevv = 0; prev = 0; elock = 0;
    for (int i = 0; i < n; i++) begin
      if (prevv != 0 && int'(sg[i]) != prev) alt = (alt < 15) ? alt + 1 : 15;
      else alt = 0;
      prevv = 1; prev = int'(sg[i]); elock = (alt >= win);
    end
    $display("run %s", tag);
    chk("R2 crossover", int'(crossover_o), ecross);
    chk("R3 overflow", int'(overflow_o), int'(eovf));
    chk("R4 overshoot", int'(overshoot_o), emax);
    chk("R5 done", int'(done_o), int'(edone));
    chk("R6 locked", int'(locked_o), int'(elock));
    chk("R1 sign", int'(sign_o), int'(sg[n-1]));
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000 && !finished) begin
        errors++; checks++;
        $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 150000);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin
    int unsigned seed;
    int k;
    seed = $urandom(32'h5eed_2b1d);
    repeat (3) @(negedge clk);
    // R9 reset values
    chk("R9 cross", int'(crossover_o), 0);
    chk("R9 overshoot", int'(overshoot_o), 0);
    chk("R9 flags", int'({overflow_o, done_o, locked_o, sign_o}), 0);
    rst_ni = 1'b1;
    tick(0, 0, 0, 0);
    chk("R9 after release", int'({overflow_o, done_o, locked_o, sign_o}), 0);

    // R1 directed: early, then tie
    do_clear();
    slot(1'b1, 0, 1'b0);
    chk("R1 early", int'(sign_o), 1);
    tick(1, 1, 0, 0);
    tick(0, 0, 0, 0);
    tick(0, 0, 0, 0);
    chk("R1 tie late", int'(sign_o), 0);

    // R2/R4/R5/R6 directed: flip at slot 5, alternating after
    for (int i = 0; i < 20; i++) begin
      sg[i] = (i < 5) ? 1'b0 : ((i % 2) == 1);
      ct[i] = (i == 7) ? 40 : (i == 12 ? 63 : i);
    end
    run("directed", 20, 6, 4, -1);

    // R5 zero settle, R8 extra start during tracking
    run("settle0", 20, 0, 2, 2);

    // R8 start during done
    for (int i = 0; i < 12; i++) begin sg[i] = (i >= 2); ct[i] = 30 - i; end
    run("start_in_done", 12, 3, 15, 9);

    // R6 loss of lock: alternating then two equal
    for (int i = 0; i < 14; i++) begin
      sg[i] = (i < 10) ? ((i % 2) == 0) : 1'b1;
      ct[i] = 5;
    end
    run("lock_drop", 14, 2, 3, -1);

    // R3 overflow
    for (int i = 0; i < 1030; i++) begin sg[i] = 1'b1; ct[i] = 50; end
    run("overflow", 1030, 4, 1, -1);

    // random runs
    for (int r = 0; r < 12; r++) begin
      int n, st, w, b;
      n = 10 + int'($urandom % 40);
      k = 1 + int'($urandom % 20);
      b = int'($urandom % 2);
      st = int'($urandom % 12);
      w = 1 + int'($urandom % 8);
      for (int i = 0; i < n; i++) begin
        if (i < k) sg[i] = b[0];
        else if ($urandom % 4 == 0) sg[i] = sg[i-1];
        else sg[i] = !sg[i-1];
        ct[i] = int'($urandom % 64);
      end
      run("random", n, st, w, int'($urandom % 60));
    end

    do_clear();
    chk("R7 final clear", int'({overflow_o, done_o, locked_o, sign_o}), 0);
    chk("R7 final cross", int'(crossover_o), 0);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule